// File: doc/BRIEF.md
# Pipelined RC6-Style Block Encryption Core

This core encrypts 128-bit blocks with an RC6-style round function built entirely in hardware. A block enters as four 32-bit words; B and D are first offset by two subkeys. A chain of identical rounds follows: each round squares-and-rotates two words, mixes them into the other two with XOR and a data-dependent rotation, adds two subkeys, and rotates the word order. A final addition of two subkeys to A and C completes the block. Every round is unrolled into its own hardware, so a new block can enter on every clock.

Software or a key-schedule engine writes the subkeys one word at a time through a small write port. The encryption path is a valid/ready stream on both sides. A parameter sets how many register stages each round is cut into, from one to four. Fewer stages give a shorter latency and fewer flops. More stages give a shorter logic path per cycle. Only the number of subkeys written changes with key size, so the core has no key-size input.

Top module: `rc6_pipe_core`

## Requirements
- R1: Word A is `in_block[31:0]`, B is `[63:32]`, C is `[95:64]` and D is `[127:96]`, and `out_block` uses the same layout. The result equals: B+=S[0], D+=S[1]; then for i=1..ROUNDS t=rotl(B*(2B+1),5), u=rotl(D*(2D+1),5), A=rotl(A^t,u mod 32)+S[2i], C=rotl(C^u,t mod 32)+S[2i+1], (A,B,C,D)=(B,C,D,A); finally A+=S[2*ROUNDS+2], C+=S[2*ROUNDS+3]. All arithmetic is modulo 2^32.
- R2: The core holds 2*ROUNDS+4 subkeys. When `key_we` is high at a rising edge, `key_data` is written to subkey `key_addr`. Any block accepted after that edge uses the new value.
- R3: A block accepted at a rising edge appears on `out_valid` exactly ROUNDS*STAGES_PER_ROUND+2 edges later, provided `out_ready` stays high.
- R4: STAGES_PER_ROUND, from 1 to 4, sets how many register stages each round is split into. It changes only the latency, never the result.
- R5: While `out_ready` is high, `in_ready` is high, so one block is accepted per cycle without gaps.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_block` stays unchanged on the next cycle. No in-flight block is lost or duplicated.
- R7: Blocks leave in the order in which they were accepted.
- R8: While `rst` is high and after its release, `out_valid` is low and `in_ready` is high until a block has passed through.
- R9: Reset clears every subkey to zero, so a block sent before any key write is encrypted with all-zero subkeys.
- R10: A cycle with `in_valid` low produces no output block. The number of blocks delivered equals the number accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_we | input | 1 | Subkey write strobe |
| key_addr | input | $clog2(2*ROUNDS+4) | Subkey index |
| key_data | input | 32 | Subkey value |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Core can take a block |
| in_block | input | 128 | Plaintext, A in the low word |
| out_valid | output | 1 | Output block valid |
| out_ready | input | 1 | Consumer takes the output |
| out_block | output | 128 | Ciphertext, A in the low word |

## Verification
The round words mix completely after a few rounds. A single wrong bit in any word, rotation amount or subkey inside the chain therefore shows up as a scrambled `out_block` on the very block that carried it, exactly ROUNDS*STAGES_PER_ROUND+2 cycles after acceptance. A fault in the valid chain or the stall enable shows at the ports in a different way: a block may arrive at the wrong edge, a block may be missing or repeated, or the output may change while it is stalled. These faults break the delivered count or the order, or change a held output, within one pass through the pipeline.

// File: rtl/rc6_pkg.sv
package rc6_pkg;

    localparam int WORD_W    = 32;
    localparam int BLOCK_W   = 4 * WORD_W;
    localparam int ROT_W     = $clog2(WORD_W);
    localparam int SUBSTEPS  = 4;   // combinational steps per round
    localparam int FIXED_ROT = 5;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
    } quad_t;

    typedef struct packed {
        quad_t w;
        word_t t;
        word_t u;
    } lane_t;

    function automatic word_t rotl(word_t x, logic [ROT_W-1:0] n);
        word_t r;
        r = (x << n) | (x >> ((ROT_W+1)'(WORD_W) - {1'b0, n}));
        return r;
    endfunction

    // x * (2x + 1) modulo 2^32
    function automatic word_t quadratic(word_t x);
        return x * {x[WORD_W-2:0], 1'b1};
    endfunction

    function automatic quad_t block_to_quad(logic [BLOCK_W-1:0] blk);
        quad_t q;
        q.a = blk[0*WORD_W +: WORD_W];
        q.b = blk[1*WORD_W +: WORD_W];
        q.c = blk[2*WORD_W +: WORD_W];
        q.d = blk[3*WORD_W +: WORD_W];
        return q;
    endfunction

    function automatic logic [BLOCK_W-1:0] quad_to_block(quad_t q);
        return {q.d, q.c, q.b, q.a};
    endfunction

    // One of the four sub-steps of a round.
    function automatic lane_t round_step(int k, lane_t s, word_t ka, word_t kb);
        lane_t n;
        n = s;
        case (k)
            0: begin
                n.t = quadratic(s.w.b);
                n.u = quadratic(s.w.d);
            end
            1: begin
                n.t = rotl(s.t, ROT_W'(FIXED_ROT));
                n.u = rotl(s.u, ROT_W'(FIXED_ROT));
            end
            2: begin
                n.w.a = rotl(s.w.a ^ s.t, s.u[ROT_W-1:0]);
                n.w.c = rotl(s.w.c ^ s.u, s.t[ROT_W-1:0]);
            end
            default: begin
                n.w.a = s.w.b;
                n.w.b = s.w.c + kb;
                n.w.c = s.w.d;
                n.w.d = s.w.a + ka;
            end
        endcase
        return n;
    endfunction

    // True when a register follows sub-step k for the given stages per round.
    function automatic bit reg_after_step(int spr, int k);
        return (((k + 1) * spr) / SUBSTEPS) != ((k * spr) / SUBSTEPS);
    endfunction

endpackage

// File: rtl/rc6_keystore.sv
module rc6_keystore
    import rc6_pkg::*;
#(
    parameter int NKEYS = 44,
    parameter int AW    = $clog2(NKEYS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  word_t         wdata,
    output word_t         keys [NKEYS]
);

    for (genvar g = 0; g < NKEYS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                keys[g] <= '0;
            end else if (we && (addr == AW'(g))) begin
                keys[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/rc6_whiten.sv
module rc6_whiten
    import rc6_pkg::*;
#(
    parameter bit POST = 1'b0
) (
    input  quad_t din,
    input  word_t k0,
    input  word_t k1,
    output quad_t dout
);

    if (POST) begin : g_post
        always_comb begin
            dout   = din;
            dout.a = din.a + k0;
            dout.c = din.c + k1;
        end
    end else begin : g_pre
        always_comb begin
            dout   = din;
            dout.b = din.b + k0;
            dout.d = din.d + k1;
        end
    end

endmodule

// File: rtl/rc6_round_chain.sv
module rc6_round_chain
    import rc6_pkg::*;
#(
    parameter int ROUNDS = 20,
    parameter int SPR    = 2,
    localparam int NSTEP = ROUNDS * SUBSTEPS,
    localparam int NRK   = 2 * ROUNDS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  quad_t in_words,
    input  logic  in_vld,
    input  word_t rkeys [NRK],
    output quad_t out_words,
    output logic  out_vld
);

    lane_t node_d [NSTEP];
    lane_t node_q [NSTEP];
    logic  vld_q  [NSTEP];

    for (genvar j = 0; j < NSTEP; j++) begin : g_step
        localparam int RI = j / SUBSTEPS;
        localparam int K  = j % SUBSTEPS;

        lane_t src;
        logic  src_vld;

        if (j == 0) begin : g_head
            assign src     = '{w: in_words, t: '0, u: '0};
            assign src_vld = in_vld;
        end else begin : g_link
            assign src     = node_q[j-1];
            assign src_vld = vld_q[j-1];
        end

        always_comb node_d[j] = round_step(K, src, rkeys[2*RI], rkeys[2*RI+1]);

        if (reg_after_step(SPR, K)) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q[j] <= 1'b0;
                end else if (adv) begin
                    vld_q[j] <= src_vld;
                end
            end
            always_ff @(posedge clk) begin
                if (adv) begin
                    node_q[j] <= node_d[j];
                end
            end
        end else begin : g_wire
            assign node_q[j] = node_d[j];
            assign vld_q[j]  = src_vld;
        end
    end

    assign out_words = node_q[NSTEP-1].w;
    assign out_vld   = vld_q[NSTEP-1];

endmodule

// File: rtl/rc6_pipe_core.sv
module rc6_pipe_core
    import rc6_pkg::*;
#(
    parameter int ROUNDS           = 20,
    parameter int STAGES_PER_ROUND = 2,
    localparam int NKEYS  = 2 * ROUNDS + 4,
    localparam int KEY_AW = $clog2(NKEYS),
    localparam int NRK    = 2 * ROUNDS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                key_we,
    input  logic [KEY_AW-1:0]   key_addr,
    input  logic [WORD_W-1:0]   key_data,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [BLOCK_W-1:0]  in_block,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [BLOCK_W-1:0]  out_block
);

    word_t keys  [NKEYS];
    word_t rkeys [NRK];

    logic  adv;
    quad_t pre_words;
    quad_t head_q;
    logic  head_vld;
    quad_t tail_words;
    logic  tail_vld;
    quad_t post_words;
    logic  out_vld_q;
    logic [BLOCK_W-1:0] out_q;

    rc6_keystore #(.NKEYS(NKEYS), .AW(KEY_AW)) u_keys (
        .clk   (clk),
        .rst   (rst),
        .we    (key_we),
        .addr  (key_addr),
        .wdata (key_data),
        .keys  (keys)
    );

    for (genvar g = 0; g < NRK; g++) begin : g_rk
        assign rkeys[g] = keys[g + 2];
    end

    // Whole pipeline moves together whenever the output slot can be refilled.
    assign adv      = !out_vld_q || out_ready;
    assign in_ready = adv;

    rc6_whiten #(.POST(1'b0)) u_pre (
        .din  (block_to_quad(in_block)),
        .k0   (keys[0]),
        .k1   (keys[1]),
        .dout (pre_words)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            head_vld <= 1'b0;
        end else if (adv) begin
            head_vld <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            head_q <= pre_words;
        end
    end

    rc6_round_chain #(.ROUNDS(ROUNDS), .SPR(STAGES_PER_ROUND)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .in_words  (head_q),
        .in_vld    (head_vld),
        .rkeys     (rkeys),
        .out_words (tail_words),
        .out_vld   (tail_vld)
    );

    rc6_whiten #(.POST(1'b1)) u_post (
        .din  (tail_words),
        .k0   (keys[NKEYS-2]),
        .k1   (keys[NKEYS-1]),
        .dout (post_words)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld_q <= 1'b0;
        end else if (adv) begin
            out_vld_q <= tail_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            out_q <= quad_to_block(post_words);
        end
    end

    assign out_valid = out_vld_q;
    assign out_block = out_q;

endmodule

// File: rtl/rc6_pipe_core_chk.sv
module rc6_pipe_core_chk #(
    parameter int ROUNDS           = 20,
    parameter int STAGES_PER_ROUND = 2,
    localparam int DEPTH = ROUNDS * STAGES_PER_ROUND + 2,
    localparam int CW    = $clog2(DEPTH + 2) + 1
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic [127:0] out_block
);

    logic [CW-1:0] inflight;
    logic          took_in;
    logic          gave_out;

    assign took_in  = in_valid && in_ready;
    assign gave_out = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight <= '0;
        end else begin
            inflight <= inflight + CW'(took_in) - CW'(gave_out);
        end
    end

    // R8
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_block)));

    // R5
    ready_flow_chk: assert property (@(posedge clk) disable iff (rst)
        out_ready |-> in_ready);

    // R10
    no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (inflight != '0));

    // R10
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        inflight <= CW'(DEPTH));

endmodule

bind rc6_pipe_core rc6_pipe_core_chk #(
    .ROUNDS           (ROUNDS),
    .STAGES_PER_ROUND (STAGES_PER_ROUND)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_block (out_block)
);

// File: tb/rc6_pipe_core_tb.sv
`timescale 1ns/1ps
module rc6_pipe_core_tb_top;

    localparam int ROUNDS = 20;
    localparam int SPR    = 2;
    localparam int NK     = 2 * ROUNDS + 4;
    localparam int AW     = $clog2(NK);
    localparam int LAT    = ROUNDS * SPR + 2;

    logic           clk = 1'b0;
    logic           rst;
    logic           key_we;
    logic [AW-1:0]  key_addr;
    logic [31:0]    key_data;
    logic           in_valid;
    logic           in_ready;
    logic [127:0]   in_block;
    logic           out_valid;
    logic           out_ready;
    logic [127:0]   out_block;

    int n_tests = 0;
    int n_fail  = 0;
    int seed_init;

    logic [31:0]  sk [NK];
    logic [127:0] src_q [$];
    logic [127:0] exp_q [$];

    always #2.5 clk = ~clk;

    rc6_pipe_core #(.ROUNDS(ROUNDS), .STAGES_PER_ROUND(SPR)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .key_we    (key_we),
        .key_addr  (key_addr),
        .key_data  (key_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_block  (in_block),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_block (out_block)
    );

    function automatic logic [31:0] rl(logic [31:0] x, int n);
        int m;
        m = n % 32;
        if (m == 0) return x;
        return (x << m) | (x >> (32 - m));
    endfunction

    function automatic logic [127:0] model(logic [127:0] blk);
        logic [31:0] a, b, c, d, t, u, tmp;
        a = blk[31:0];  b = blk[63:32];  c = blk[95:64];  d = blk[127:96];
        b = b + sk[0];
        d = d + sk[1];
        for (int i = 1; i <= ROUNDS; i++) begin
            t = rl(b * (2 * b + 1), 5);
            u = rl(d * (2 * d + 1), 5);
            a = rl(a ^ t, int'(u[4:0])) + sk[2*i];
            c = rl(c ^ u, int'(t[4:0])) + sk[2*i+1];
            tmp = a; a = b; b = c; c = d; d = tmp;
        end
        a = a + sk[2*ROUNDS+2];
        c = c + sk[2*ROUNDS+3];
        return {d, c, b, a};
    endfunction

    function automatic logic [127:0] rnd_block();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_key(input int idx, input logic [31:0] val);
        @(negedge clk);
        key_we   = 1'b1;
        key_addr = AW'(idx);
        key_data = val;
        sk[idx]  = val;
        @(negedge clk);
        key_we   = 1'b0;
    endtask

    // Streams src_q through the core with the given valid/ready percentages.
    task automatic run_stream(input int pv, input int pr, input string tag);
        bit          hold_pend = 1'b0;
        logic [127:0] held = '0;
        int          guard = 0;
        while ((src_q.size() > 0 || exp_q.size() > 0) && guard < 20000) begin
            guard++;
            @(negedge clk);
            in_valid  = (src_q.size() > 0) && ($urandom_range(99) < pv);
            in_block  = (src_q.size() > 0) ? src_q[0] : '0;
            out_ready = ($urandom_range(99) < pr);
            #1;
            if (hold_pend) begin
                // R6: stalled output held one cycle later
                check(out_valid && (out_block === held), "R6 hold", out_block, held);
            end
            hold_pend = out_valid && !out_ready;
            held      = out_block;
            if (pr == 100) begin
                // R5: ready flows through when consumer is ready
                check(in_ready === 1'b1, "R5 in_ready", 128'(in_ready), 128'd1);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    // R10: no output without an accepted input
                    check(1'b0, "R10 spurious output", out_block, '0);
                end else begin
                    // R1, R7: value and order
                    check(out_block === exp_q[0], {"R7 R1 ", tag}, out_block, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
            if (in_valid && in_ready) begin
                exp_q.push_back(model(src_q[0]));
                void'(src_q.pop_front());
            end
        end
        // R10: everything accepted was delivered
        check(exp_q.size() == 0 && src_q.size() == 0, {"R10 drain ", tag},
              128'(exp_q.size()), 128'd0);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] blk, exp;
        int lat;
        seed_init = $urandom(32'd9157);
        for (int i = 0; i < NK; i++) sk[i] = '0;
        rst = 1'b1; key_we = 1'b0; key_addr = '0; key_data = '0;
        in_valid = 1'b0; in_block = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: quiet during reset
        check(out_valid === 1'b0, "R8 out_valid in reset", 128'(out_valid), 128'd0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(out_valid === 1'b0, "R8 out_valid after reset", 128'(out_valid), 128'd0);
        check(in_ready === 1'b1, "R8 in_ready after reset", 128'(in_ready), 128'd1);

        // R3, R4, R9: single block with reset keys, measure latency
        @(negedge clk);
        blk = 128'h0123456789abcdef_fedcba9876543210;
        exp = model(blk);
        in_valid = 1'b1; in_block = blk; out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        #1;
        while (!out_valid && lat < 500) begin
            @(posedge clk);
            @(negedge clk);
            #1;
            lat++;
        end
        check(lat == LAT, "R3 R4 latency", 128'(lat), 128'(LAT));
        check(out_block === exp, "R9 zero subkeys", out_block, exp);
        @(negedge clk);
        #1;
        check(out_valid === 1'b0, "R10 single bubble", 128'(out_valid), 128'd0);

        // R2: load random subkeys
        for (int i = 0; i < NK; i++) write_key(i, $urandom());

        // Directed corners, full throughput
        src_q.push_back('0);
        src_q.push_back({128{1'b1}});
        src_q.push_back({32{4'ha}});
        src_q.push_back(128'h1);
        for (int i = 0; i < 30; i++) src_q.push_back(rnd_block());
        run_stream(100, 100, "burst");

        // Random valid and ready
        for (int i = 0; i < 300; i++) src_q.push_back(rnd_block());
        run_stream(60, 55, "random");

        // Heavy backpressure
        for (int i = 0; i < 100; i++) src_q.push_back(rnd_block());
        run_stream(90, 20, "stall");

        // R2: rewrite a pre, round and post subkey, then encrypt again
        write_key(0, 32'hdeadbeef);
        write_key(7, 32'h00000001);
        write_key(NK - 1, 32'h80000000);
        for (int i = 0; i < 20; i++) src_q.push_back(rnd_block());
        run_stream(100, 100, "R2 rekey");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule